// File: doc/BRIEF.md
# Eight-Entry Register Stack with Status Flags

This block is a last-in, first-out store of eight 12-bit words. A CPU datapath uses it to save and restore working registers and the program counter, for example around an interrupt service routine. A push moves the pointer up one place and then writes the input word into the location the pointer now selects. A pop loads the top word into the output register and then moves the pointer down one place. A peek loads the top word without moving the pointer. A 3-to-8 decoder driven by the write pointer selects which location receives each push.

Two flags, empty and overflow, are meant to serve as conditions for jump instructions, next to the usual sign, carry and zero flags. The overflow flag is sticky. A configuration input decides whether overflow also raises a halt request to the sequencer. This block does not choose which register supplies or receives the data.

Top module: `reg_lifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, ovf_o=0, rd_data_o=0, underflow_o=0, conflict_o=0 and halt_req_o=0.
- R2: A push stores wr_data_i and clears empty_o on the next cycle. A following peek returns the stored word.
- R3: Pops return words in the reverse of their push order. The word appears on rd_data_o in the cycle after the pop request.
- R4: A pop reads the entry before it moves the pointer. After a pop, a peek returns the entry below the one that was popped.
- R5: A peek does not move the pointer. Repeated peeks, and a pop after them, all return the same word.
- R6: After 8 pushes, full_o=1. A push while full is discarded, so the top entry is unchanged, and it sets ovf_o.
- R7: Only reset clears ovf_o. Pops that drain the stack leave ovf_o at 1.
- R8: halt_req_o=1 exactly when ovf_o=1 and halt_en_i=1. The request follows halt_en_i without a clock.
- R9: A pop while empty leaves the stack empty and sets rd_data_o to 0. It pulses underflow_o high for one cycle.
- R10: When push and pop are requested in the same cycle, only the push is performed and rd_data_o holds its value. conflict_o pulses high for one cycle.
- R11: rd_data_o changes only on a pop or a peek. A push alone or an idle cycle leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| peek_i | input | 1 | Peek request |
| wr_data_i | input | 12 | Word to push |
| halt_en_i | input | 1 | Overflow raises a halt request when set |
| rd_data_o | output | 12 | Registered word from the last pop or peek |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds eight entries |
| ovf_o | output | 1 | Sticky overflow flag |
| halt_req_o | output | 1 | Halt request to the sequencer |
| underflow_o | output | 1 | One-cycle pulse: pop while empty |
| conflict_o | output | 1 | One-cycle pulse: push and pop together |

## Verification
The assertions assume that requests are sampled only at rising clock edges and are stable around them. They also assume that any combination of push, pop and peek may be applied, because the priority order push, then pop, then peek resolves every combination. The stimulus changes inputs only on falling edges and returns them to idle after each step. It deliberately drives the illegal cases: pushes past full, pops past empty and a combined push and pop, so that the guarded paths are exercised. The halt enable is changed only between steps, which keeps the unclocked halt path out of edge races.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  localparam int STK_DEPTH = 8;
  localparam int STK_DW    = 12;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_DROP,
    OP_POP,
    OP_UNDER,
    OP_PEEK
  } stk_op_e;
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             peek_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic             rd_load_o,
  output logic             rd_zero_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             underflow_o,
  output logic             conflict_o
);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_TOP) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_TOP : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, under_q, conf_q;
  stk_op_e          op;
  logic             is_empty, is_full;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CNT_MAX);

  always_comb begin
    op = OP_IDLE;
    if (push_i)      op = is_full  ? OP_DROP  : OP_PUSH;
    else if (pop_i)  op = is_empty ? OP_UNDER : OP_POP;
    else if (peek_i) op = OP_PEEK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= PTR_TOP;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      under_q <= 1'b0;
      conf_q  <= 1'b0;
    end else begin
      under_q <= (op == OP_UNDER);
      conf_q  <= push_i & pop_i;
      case (op)
        OP_PUSH: begin
          ptr_q <= wrap_inc(ptr_q);
          cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          ptr_q <= wrap_dec(ptr_q);
          cnt_q <= cnt_q - 1'b1;
        end
        OP_DROP: ovf_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign wr_en_o     = (op == OP_PUSH);
  assign wr_addr_o   = wrap_inc(ptr_q);
  assign rd_addr_o   = ptr_q;
  assign rd_load_o   = (op == OP_POP) || (op == OP_UNDER) || (op == OP_PEEK);
  assign rd_zero_o   = is_empty;
  assign empty_o     = is_empty;
  assign full_o      = is_full;
  assign ovf_o       = ovf_q;
  assign underflow_o = under_q;
  assign conflict_o  = conf_q;

  // R2: an accepted push adds exactly one entry
  a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4: an accepted pop removes exactly one entry
  a_r4_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6: a push while full changes nothing and sets the overflow flag
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> (full_o && ovf_o && $stable(ptr_q)));
  // R7: the overflow flag never falls outside reset
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R5: a peek alone leaves the pointer in place
  a_r5_peek_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_i && !push_i && !pop_i) |=> $stable(ptr_q) && $stable(cnt_q));
endmodule

// File: rtl/lifo_store.sv
module lifo_store
  import lifo_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  parameter int DW    = STK_DW,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  input  logic             rd_load_i,
  input  logic             rd_zero_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] row_we;
  logic [DW-1:0]    rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign row_we[g] = wr_en_i && (wr_addr_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)         mem[g] <= '0;
      else if (row_we[g]) mem[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_q <= '0;
    else if (rd_load_i) rd_q <= rd_zero_i ? '0 : mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  // R2: the decoder enables at most one location
  a_r2_onehot_row: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we));
  // R2: the selected location captures the pushed word
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));
  // R11: the output register moves only on a load
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load_i |=> $stable(rd_q));
endmodule

// File: rtl/reg_lifo.sv
module reg_lifo
  import lifo_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  parameter int DW    = STK_DW,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          peek_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          halt_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          halt_req_o,
  output logic          underflow_o,
  output logic          conflict_o
);
  logic             wr_en, rd_load, rd_zero;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  lifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .pop_i(pop_i), .peek_i(peek_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .rd_load_o(rd_load), .rd_zero_o(rd_zero),
    .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o),
    .underflow_o(underflow_o), .conflict_o(conflict_o)
  );

  lifo_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr), .rd_load_i(rd_load), .rd_zero_i(rd_zero),
    .rd_data_o(rd_data_o)
  );

  assign halt_req_o = ovf_o & halt_en_i;

  // R9: an underflow pulse comes with a zero output word
  a_r9_under_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (rd_data_o == '0) && empty_o);
  // R10: a conflict never shrinks the stack
  a_r10_conf_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (conflict_o && !empty_o));
endmodule

// File: tb/test_reg_lifo.sv
`timescale 1ns/1ps
module test_reg_lifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0, halt_en_i = 1'b0;
  logic [11:0] wr_data_i = '0;
  logic [11:0] rd_data_o;
  logic        empty_o, full_o, ovf_o, halt_req_o, underflow_o, conflict_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  reg_lifo i_reg_lifo (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .peek_i(peek_i),
    .wr_data_i(wr_data_i), .halt_en_i(halt_en_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .halt_req_o(halt_req_o),
    .underflow_o(underflow_o), .conflict_o(conflict_o)
  );

  // [31]push [30]pop [29]peek [28:17]data [16:5]rd [4]empty [3]full [2]ovf [1]under [0]conflict
  localparam logic [31:0] VEC [12] = '{
    {3'b100, 12'h111, 12'h000, 5'b00000},  // R2 push
    {3'b100, 12'h222, 12'h000, 5'b00000},  // R11 push leaves rd
    {3'b001, 12'h000, 12'h222, 5'b00000},  // R2 peek sees top
    {3'b001, 12'h000, 12'h222, 5'b00000},  // R5 peek again
    {3'b010, 12'h000, 12'h222, 5'b00000},  // R5 pop same word
    {3'b001, 12'h000, 12'h111, 5'b00000},  // R4 entry below
    {3'b110, 12'h333, 12'h111, 5'b00001},  // R10 push wins
    {3'b010, 12'h000, 12'h333, 5'b00000},  // R3 reverse order
    {3'b010, 12'h000, 12'h111, 5'b10000},  // R3 last pop, empty
    {3'b010, 12'h000, 12'h000, 5'b10010},  // R9 underflow
    {3'b001, 12'h000, 12'h000, 5'b10000},  // R9 peek empty, pulse gone
    {3'b100, 12'hABC, 12'h000, 5'b00000}   // R2 push after empty
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic pk, input logic [11:0] d);
    @(negedge clk);
    push_i = pu; pop_i = po; peek_i = pk; wr_data_i = d;
    @(posedge clk);
    #1;
    push_i = 1'b0; pop_i = 1'b0; peek_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 rd", rd_data_o, 12'h000);
    chk("R1 flags", {7'd0, empty_o, full_o, ovf_o, underflow_o, conflict_o}, 12'h010);
    chk("R1 halt", {11'd0, halt_req_o}, 12'h000);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28:17]);
      chk($sformatf("R3 vec%0d rd", i), rd_data_o, VEC[i][16:5]);
      chk($sformatf("R11 vec%0d flags", i),
          {7'd0, empty_o, full_o, ovf_o, underflow_o, conflict_o}, {7'd0, VEC[i][4:0]});
    end

    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 12'h100 + 12'(i));
    chk("R6 full", {10'd0, full_o, ovf_o}, 12'h002);
    step(1'b1, 1'b0, 1'b0, 12'hFFF);
    chk("R6 ovf", {10'd0, full_o, ovf_o}, 12'h003);
    chk("R8 halt off", {11'd0, halt_req_o}, 12'h000);
    @(negedge clk); halt_en_i = 1'b1; #1;
    chk("R8 halt on", {11'd0, halt_req_o}, 12'h001);
    step(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R6 top kept", rd_data_o, 12'h107);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, 1'b0, 12'h000);
      chk("R3 drain", rd_data_o, 12'h107 - 12'(i));
    end
    chk("R7 ovf kept", {10'd0, empty_o, ovf_o}, 12'h003);
    step(1'b0, 1'b1, 1'b0, 12'h000);
    chk("R9 under", {10'd0, underflow_o, empty_o}, 12'h003);
    step(1'b0, 1'b0, 1'b0, 12'h000);
    chk("R9 pulse", {11'd0, underflow_o}, 12'h000);
    do_reset();
    chk("R7 reset clears", {10'd0, ovf_o, halt_req_o}, 12'h000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule